// File: doc/BRIEF.md
# Parallel Port Interrupt and Mode Status Register

This block is one byte-wide register in the register file of a bridge that connects a host bus to a parallel printer port. Software writes the upper three bits to choose the operating mode of the port. Software reads the register to see the chosen mode, three latched interrupt events and two live buffer-occupancy indications.

Two of the interrupt events come from the port's own status lines, acknowledge and fault. These lines are asynchronous to the register clock, so each passes through a two-stage synchroniser before edge detection. The third event is raised when inbound bulk data is waiting. The events are gated by an enable bit and two mask bits, which belong to a neighbouring control register and arrive here as plain inputs.

A read strobe at any address of the register file clears all latched events. The request output is high while any event is latched, and the host uses it to raise an interrupt.

Top module: `pp_irq_status_reg`

## Requirements
- R1: The readable byte is laid out as follows: bits 7:5 hold the mode, bit 4 the acknowledge event, bit 3 the fault event, bit 2 the inbound-data event, bit 1 inbound-empty and bit 0 outbound-empty. `rdata_o` carries this byte while `rd_i` is high and `addr_i` equals `REG_ADDR`. At every other time `rdata_o` is 0.
- R2: After reset, `mode_o` is 000 and `irq_o` is 0. With no buffered data the register reads 0x03.
- R3: A write strobe at `REG_ADDR` stores `wdata_i[7:5]` into the mode at the next edge. Codes 101 to 111 are reserved and are stored as written. Writes to other addresses and the lower write bits have no effect. The codes are 000 standard (output-only data), 001 bidirectional, 010 compatibility with hardware handshake, 011 extended capabilities and 100 enhanced parallel.
- R4: A rising edge of `nack_i` sets the acknowledge event, but only while `irq_en_i` is 1. The flag reads 1 after the third clock edge that follows the change.
- R5: A falling edge of `nfault_i` sets the fault event while `nfault_mask_i` is 0. The latency is the same as for R4.
- R6: When `nfault_mask_i` goes from 1 to 0 while the synchronised fault line is low, the fault event is set at the next edge.
- R7: While `bin_avail_i` is 1 and `bin_mask_i` is 0, the inbound-data event is set at each edge.
- R8: A read strobe at any address clears all three events at the next edge.
- R9: Inbound-empty reads as the inverse of `bin_avail_i`, and outbound-empty reads as the inverse of `bout_pend_i`, in the same cycle, with no latching.
- R10: `irq_o` is high exactly while at least one event is latched.
- R11: When a set condition and a clearing read occur in the same cycle, the event stays set.
- R12: A read returns the event values from before the clear that this same read causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register file address |
| rd_i | input | 1 | Read strobe, any address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| nack_i | input | 1 | Port acknowledge line, asynchronous |
| nfault_i | input | 1 | Port fault line, active low, asynchronous |
| irq_en_i | input | 1 | Acknowledge event enable |
| nfault_mask_i | input | 1 | Fault event mask, 1 masks |
| bin_mask_i | input | 1 | Inbound-data event mask, 1 masks |
| bin_avail_i | input | 1 | Inbound bulk data waiting |
| bout_pend_i | input | 1 | Outbound data buffered or in transfer |
| rdata_o | output | 8 | Read data |
| mode_o | output | 3 | Current port mode |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and the empty bits are combinational, so each read is scored in the same cycle it is issued. Mode writes, mask-removal events, inbound-data events and clears appear one edge after their stimulus. Line edges on acknowledge and fault take three edges: two for the synchroniser and one for the flag. The driver changes inputs 1 ns after a rising edge and waits exactly that many edges. The monitor pops and compares each expected read at the falling edge inside the strobe cycle. Direct checks of `mode_o` and `irq_o` are taken 1 ns after the edge on which they are due.

// File: rtl/pp_irq_pkg.sv
package pp_irq_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_NACK  = 2;
  localparam int FLG_NFLT  = 1;
  localparam int FLG_BIN   = 0;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_STD    = 3'b000,
    PM_BIDIR  = 3'b001,
    PM_COMPAT = 3'b010,
    PM_XCAP   = 3'b011,
    PM_ENH    = 3'b100
  } pp_mode_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pp_evt_flag.sv
module pp_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set takes priority so a coincident event survives the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pp_irq_status_reg.sv
module pp_irq_status_reg
  import pp_irq_pkg::*;
#(
  parameter int                ADDR_W      = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 3'd6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              nack_i,
  input  logic              nfault_i,
  input  logic              irq_en_i,
  input  logic              nfault_mask_i,
  input  logic              bin_mask_i,
  input  logic              bin_avail_i,
  input  logic              bout_pend_i,
  output logic [7:0]        rdata_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o
);
  localparam int LN_NACK = 1;
  localparam int LN_NFLT = 0;

  logic [1:0]           lines_s, lines_prev_q;
  logic                 mask_prev_q;
  logic [MODE_W-1:0]    mode_q;
  logic [NUM_FLAGS-1:0] set_vec, flags_q;
  logic                 reg_sel;

  pp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nack_i, nfault_i}),
    .q_o   (lines_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_prev_q <= 2'b11;
      mask_prev_q  <= 1'b0;
    end else begin
      lines_prev_q <= lines_s;
      mask_prev_q  <= nfault_mask_i;
    end
  end

  assign reg_sel = (addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mode_q <= PM_STD;
    else if (wr_i && reg_sel)  mode_q <= wdata_i[7:5];
  end

  always_comb begin
    set_vec[FLG_NACK] = irq_en_i & ~lines_prev_q[LN_NACK] & lines_s[LN_NACK];
    // falling fault edge, or mask lifted while fault already asserted
    set_vec[FLG_NFLT] = ~nfault_mask_i & ~lines_s[LN_NFLT]
                      & (lines_prev_q[LN_NFLT] | mask_prev_q);
    set_vec[FLG_BIN]  = bin_avail_i & ~bin_mask_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pp_evt_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[g]),
      .clr_i (rd_i),
      .flag_o(flags_q[g])
    );
  end

  assign rdata_o = (rd_i && reg_sel) ? {mode_q, flags_q, ~bin_avail_i, ~bout_pend_i} : 8'h00;
  assign mode_o  = mode_q;
  assign irq_o   = |flags_q;
endmodule

// File: rtl/pp_irq_status_chk.sv
module pp_irq_status_chk
  import pp_irq_pkg::*;
#(
  parameter int                ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'd6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 rd_i,
  input logic                 wr_i,
  input logic [7:0]           wdata_i,
  input logic                 bin_avail_i,
  input logic                 bin_mask_i,
  input logic                 bout_pend_i,
  input logic [7:0]           rdata_o,
  input logic [MODE_W-1:0]    mode_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flags_q
);
  // R3
  mode_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_ADDR) |=> mode_o == $past(wdata_i[7:5]));
  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == REG_ADDR) |=> $stable(mode_o));
  // R7
  bin_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_avail_i && !bin_mask_i) |=> flags_q[FLG_BIN]);
  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !(bin_avail_i && !bin_mask_i)) |=> !flags_q[FLG_BIN]);
  // R10
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i) |=> irq_o);
  // R9
  empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_ADDR) |-> (rdata_o[1] == !bin_avail_i && rdata_o[0] == !bout_pend_i));
  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == REG_ADDR) |-> rdata_o == 8'h00);
endmodule

bind pp_irq_status_reg pp_irq_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .bin_avail_i(bin_avail_i),
  .bin_mask_i (bin_mask_i),
  .bout_pend_i(bout_pend_i),
  .rdata_o    (rdata_o),
  .mode_o     (mode_o),
  .irq_o      (irq_o),
  .flags_q    (flags_q)
);

// File: tb/pp_irq_status_reg_bench.sv
module pp_irq_status_reg_bench;
  localparam logic [2:0] RA = 3'd6;

  logic       clk_i = 0, rst_ni = 0;
  logic [2:0] addr_i = 0;
  logic       rd_i = 0, wr_i = 0;
  logic [7:0] wdata_i = 0;
  logic       nack_i = 1, nfault_i = 1, irq_en_i = 0, nfault_mask_i = 0;
  logic       bin_mask_i = 1, bin_avail_i = 0, bout_pend_i = 0;
  logic [7:0] rdata_o;
  logic [2:0] mode_o;
  logic       irq_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  pp_irq_status_reg u_pp_irq_status_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .nack_i(nack_i), .nfault_i(nfault_i), .irq_en_i(irq_en_i),
    .nfault_mask_i(nfault_mask_i), .bin_mask_i(bin_mask_i), .bin_avail_i(bin_avail_i),
    .bout_pend_i(bout_pend_i), .rdata_o(rdata_o), .mode_o(mode_o), .irq_o(irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: queue expected read data, then strobe
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr_i = a; rd_i = 1;
    tick(1);
    rd_i = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1;
    tick(1);
    wr_i = 0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rd_i && rst_ni) begin
      if (exp_q.size() == 0) chk(8'hxx, 8'h00, "queue underrun");
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata_o, e, t);
      end
    end
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(1);
    chk({5'b0, mode_o}, 8'h00, "R2 mode after reset");
    chk({7'b0, irq_o}, 8'h00, "R2 irq after reset");
    rd(RA, 8'h03, "R2 reset value");

    wr(RA, 8'h9F);
    chk({5'b0, mode_o}, 8'h04, "R3 mode write");
    rd(RA, 8'h83, "R1 R3 layout");
    wr(RA, 8'hE0);
    wr(3'd2, 8'h20);
    chk({5'b0, mode_o}, 8'h07, "R3 reserved stored, other addr ignored");
    rd(3'd1, 8'h00, "R1 other address reads zero");

    irq_en_i = 1; nack_i = 0; tick(4);
    nack_i = 1; tick(3);
    chk({7'b0, irq_o}, 8'h01, "R10 irq from nack event");
    rd(RA, 8'hF3, "R4 nack event");
    rd(RA, 8'hE3, "R8 cleared by read");
    chk({7'b0, irq_o}, 8'h00, "R10 irq low after clear");

    irq_en_i = 0; nack_i = 0; tick(4);
    nack_i = 1; tick(4);
    rd(RA, 8'hE3, "R4 gated by enable");

    nfault_i = 0; tick(4);
    rd(RA, 8'hEB, "R5 fault falling edge");
    rd(RA, 8'hE3, "R8 fault cleared");
    nfault_i = 1; tick(4);

    nfault_mask_i = 1; tick(1);
    nfault_i = 0; tick(4);
    rd(RA, 8'hE3, "R5 masked fault edge");
    nfault_mask_i = 0; tick(1);
    rd(RA, 8'hEB, "R6 unmask while fault low");
    nfault_i = 1; tick(4);
    rd(RA, 8'hE3, "R6 rising fault no event");

    bin_mask_i = 0; bin_avail_i = 1; tick(1);
    chk({7'b0, irq_o}, 8'h01, "R7 irq from inbound data");
    rd(RA, 8'hE5, "R7 R9 inbound event and empty bit");
    rd(RA, 8'hE5, "R11 set beats clear");
    bin_mask_i = 1;
    rd(RA, 8'hE5, "R12 read shows pre-clear flags");
    rd(RA, 8'hE1, "R8 inbound cleared");
    bin_avail_i = 0;
    rd(RA, 8'hE3, "R9 inbound empty live");
    bout_pend_i = 1;
    rd(RA, 8'hE2, "R9 outbound pending");
    bout_pend_i = 0;

    irq_en_i = 1; nack_i = 0; tick(4);
    nack_i = 1; tick(3);
    rd(3'd0, 8'h00, "R8 read at other address");
    chk({7'b0, irq_o}, 8'h00, "R8 other-address read clears");
    rd(RA, 8'hE3, "R8 flags clear after foreign read");

    tick(2);
    chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule